// File: doc/BRIEF.md
# IR Pulse-Distance Frame Sequencer

This block turns a packed bit buffer into an infrared frame made of gate-on and gate-off intervals. Every interval is counted in ticks of a slow timebase, typically 10 kHz, that arrives as a one-cycle enable. The `gate` output keys an external carrier generator, and `busy` stays high from the moment a request is accepted until the final interval of the final frame has elapsed.

A request carries its own timing set. This set has a start symbol, a one symbol and a zero symbol, each with an on length and an off length. It also carries an optional stop symbol, a frame count and an idle gap between frames. A 2-bit mode selects one of three frame shapes. Plain frames send only buffer bits. Sync frames insert an extra marker symbol after the first sixteen data symbols. Twin frames send every frame after the first without a start symbol, beginning at a later buffer position, so that the buffer can hold a second copy of the payload (for example an inverted command).

Top module: `irtx_frame_seq`

## Requirements
- R1: After reset, `gate` and `busy` are 0.
- R2: A `req` is accepted only when `busy` is 0 and `mode` is not 3. `busy` is 1 after the accepting edge. A `req` while `busy` is 1 has no effect on the frame in progress, and the inputs are sampled only on the accepting edge.
- R3: A symbol with on length P and off length Q is emitted over P+Q+1 ticks: `gate` is 1 for P ticks, then 0 for Q ticks, then 0 for one closing tick. `gate` and `busy` change only on edges where `tick` is 1, apart from the accepting edge.
- R4: Each frame opens with a start symbol (start on and off lengths), followed by `bit_count` data symbols. Data symbol n uses `frame_buf[8*(n/8) + 7 - (n%8)]`, so byte k sits in bits [8k+7:8k] and is sent most significant bit first. A 1 uses the one lengths and a 0 uses the zero lengths.
- R5: When `stop_en` is 1, each frame ends with a stop symbol. It uses the zero on length, and its off length is the zero off length, except in the last frame, where the off length is 255 ticks.
- R6: The block sends `frame_total` frames, with a value of 0 treated as 1. Between consecutive frames, `gate` stays 0 for `frame_gap` ticks. `busy` falls on the closing tick of the last symbol of the last frame.
- R7: In mode 1 (sync), symbol position 16 is a marker with the zero on length and the start off length. Any later position n uses buffer bit n-1, and `bit_count` counts the marker.
- R8: In mode 2 (twin), every frame after the first has no start symbol. Its data positions run from 16 up to 2*`bit_count`, inclusive, and are read from the buffer at those positions. The stop symbol then follows when it is enabled.
- R9: A `req` with `mode` equal to 3 is rejected: `busy` and `gate` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable, one cycle per interval tick |
| req | input | 1 | Start request |
| mode | input | 2 | 0 plain, 1 sync marker, 2 twin frame, 3 reserved |
| frame_buf | input | 8*BUF_BYTES | Packed payload, byte k in bits [8k+7:8k] |
| bit_count | input | IDX_W | Number of data symbols per frame |
| start_on | input | CNT_W | Start symbol on ticks |
| start_off | input | CNT_W | Start symbol off ticks |
| one_on | input | CNT_W | One symbol on ticks |
| one_off | input | CNT_W | One symbol off ticks |
| zero_on | input | CNT_W | Zero symbol on ticks |
| zero_off | input | CNT_W | Zero symbol off ticks |
| stop_en | input | 1 | Append a stop symbol to each frame |
| frame_total | input | CNT_W | Number of frames per request |
| frame_gap | input | GAP_W | Idle ticks between frames |
| gate | output | 1 | Carrier gate |
| busy | output | 1 | Transmission in progress |

## Verification
The assertions assume that `tick` is a single-cycle enable and that the request inputs only matter on the accepting edge. They also take for granted that `bit_count` stays within the buffer: in twin mode, 2*`bit_count` is at most the buffer size, and `frame_gap` is at least 1 when more than one frame is requested. The stimulus keeps every request inside these limits and changes the inputs only at the falling edge. It also uses a tick that is sometimes present on every cycle and sometimes only on every third cycle, which exercises the cycles in which the block must hold still.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_SYNC  = 2'd1,
    MODE_TWIN  = 2'd2,
    MODE_RSVD  = 2'd3
  } irtx_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } irtx_state_e;

endpackage

// File: rtl/irtx_gap_timer.sv
module irtx_gap_timer #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             step,
  input  logic [GAP_W-1:0] limit,
  output logic             expire
);

  logic [GAP_W-1:0] cnt;
  logic [GAP_W:0]   nxt;

  assign nxt    = {1'b0, cnt} + 1'b1;
  assign expire = !hold && step && (nxt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= nxt[GAP_W-1:0];
    end
  end

endmodule

// File: rtl/irtx_sym_sel.sv
module irtx_sym_sel #(
  parameter int BUF_BITS = 40,
  parameter int CNT_W    = 8,
  parameter int LEN_W    = 7,
  parameter int SYNC_AT  = 16
) (
  input  logic                in_start,
  input  logic [LEN_W-1:0]    idx,
  input  logic [LEN_W-1:0]    len_eff,
  input  logic                sync_en,
  input  logic                last_frame,
  input  logic [BUF_BITS-1:0] frame_buf,
  input  logic [CNT_W-1:0]    start_on,
  input  logic [CNT_W-1:0]    start_off,
  input  logic [CNT_W-1:0]    one_on,
  input  logic [CNT_W-1:0]    one_off,
  input  logic [CNT_W-1:0]    zero_on,
  input  logic [CNT_W-1:0]    zero_off,
  output logic [CNT_W-1:0]    sym_on,
  output logic [CNT_W-1:0]    sym_off
);

  localparam int              LIN_N    = 2 ** LEN_W;
  localparam logic [LEN_W-1:0] SYNC_IDX = LEN_W'(SYNC_AT);

  // Linear, transmission-ordered view of the buffer, zero padded.
  logic [LIN_N-1:0] lin;

  for (genvar g = 0; g < LIN_N; g++) begin : g_lin
    if (g < BUF_BITS) begin : g_real
      assign lin[g] = frame_buf[8*(g/8) + 7 - (g%8)];
    end else begin : g_pad
      assign lin[g] = 1'b0;
    end
  end

  logic [LEN_W-1:0] bit_pos;
  logic             bit_val;

  assign bit_pos = (sync_en && (idx > SYNC_IDX)) ? idx - 1'b1 : idx;
  assign bit_val = lin[bit_pos];

  always_comb begin
    if (in_start) begin
      sym_on  = start_on;
      sym_off = start_off;
    end else if (idx < len_eff) begin
      if (sync_en && (idx == SYNC_IDX)) begin
        sym_on  = zero_on;
        sym_off = start_off;
      end else if (bit_val) begin
        sym_on  = one_on;
        sym_off = one_off;
      end else begin
        sym_on  = zero_on;
        sym_off = zero_off;
      end
    end else begin
      sym_on  = zero_on;
      sym_off = last_frame ? {CNT_W{1'b1}} : zero_off;
    end
  end

endmodule

// File: rtl/irtx_frame_seq.sv
module irtx_frame_seq
  import irtx_pkg::*;
#(
  parameter  int BUF_BYTES = 5,
  parameter  int CNT_W     = 8,
  parameter  int GAP_W     = 16,
  parameter  int SYNC_AT   = 16,
  parameter  int TWIN_AT   = 16,
  localparam int BUF_BITS  = 8 * BUF_BYTES,
  localparam int IDX_W     = $clog2(BUF_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                req,
  input  logic [1:0]          mode,
  input  logic [BUF_BITS-1:0] frame_buf,
  input  logic [IDX_W-1:0]    bit_count,
  input  logic [CNT_W-1:0]    start_on,
  input  logic [CNT_W-1:0]    start_off,
  input  logic [CNT_W-1:0]    one_on,
  input  logic [CNT_W-1:0]    one_off,
  input  logic [CNT_W-1:0]    zero_on,
  input  logic [CNT_W-1:0]    zero_off,
  input  logic                stop_en,
  input  logic [CNT_W-1:0]    frame_total,
  input  logic [GAP_W-1:0]    frame_gap,
  output logic                gate,
  output logic                busy
);

  localparam int               LEN_W    = IDX_W + 1;
  localparam logic [LEN_W-1:0] TWIN_IDX = LEN_W'(TWIN_AT);

  irtx_state_e state;
  irtx_mode_e  mode_q;

  logic [BUF_BITS-1:0] buf_q;
  logic [IDX_W-1:0]    bitcnt_q;
  logic [CNT_W-1:0]    s_on_q, s_off_q, o_on_q, o_off_q, z_on_q, z_off_q;
  logic                stop_q;
  logic [CNT_W-1:0]    reps_q;
  logic [GAP_W-1:0]    gap_q;

  logic                in_start;
  logic [LEN_W-1:0]    idx;
  logic [LEN_W-1:0]    len_eff;
  logic [CNT_W-1:0]    on_cnt, off_cnt;
  logic [CNT_W-1:0]    rep_done;

  logic [CNT_W-1:0]    sym_on, sym_off;
  logic [LEN_W:0]      total, next_idx;
  logic                frame_end, last_frame, gap_expire;

  assign total      = {1'b0, len_eff} + {{LEN_W{1'b0}}, stop_q};
  assign next_idx   = in_start ? {1'b0, idx} : {1'b0, idx} + 1'b1;
  assign frame_end  = next_idx >= total;
  assign last_frame = ({1'b0, rep_done} + 1'b1) >= {1'b0, reps_q};

  irtx_sym_sel #(
    .BUF_BITS (BUF_BITS),
    .CNT_W    (CNT_W),
    .LEN_W    (LEN_W),
    .SYNC_AT  (SYNC_AT)
  ) sym_sel_i (
    .in_start   (in_start),
    .idx        (idx),
    .len_eff    (len_eff),
    .sync_en    (mode_q == MODE_SYNC),
    .last_frame (last_frame),
    .frame_buf  (buf_q),
    .start_on   (s_on_q),
    .start_off  (s_off_q),
    .one_on     (o_on_q),
    .one_off    (o_off_q),
    .zero_on    (z_on_q),
    .zero_off   (z_off_q),
    .sym_on     (sym_on),
    .sym_off    (sym_off)
  );

  irtx_gap_timer #(
    .GAP_W (GAP_W)
  ) gap_timer_i (
    .clk    (clk),
    .rst    (rst),
    .hold   (state != ST_WAIT),
    .step   (tick),
    .limit  (gap_q),
    .expire (gap_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mode_q   <= MODE_PLAIN;
      buf_q    <= '0;
      bitcnt_q <= '0;
      s_on_q   <= '0;
      s_off_q  <= '0;
      o_on_q   <= '0;
      o_off_q  <= '0;
      z_on_q   <= '0;
      z_off_q  <= '0;
      stop_q   <= 1'b0;
      reps_q   <= '0;
      gap_q    <= '0;
      in_start <= 1'b0;
      idx      <= '0;
      len_eff  <= '0;
      on_cnt   <= '0;
      off_cnt  <= '0;
      rep_done <= '0;
      gate     <= 1'b0;
      busy     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req && (irtx_mode_e'(mode) != MODE_RSVD)) begin
            state    <= ST_RUN;
            mode_q   <= irtx_mode_e'(mode);
            buf_q    <= frame_buf;
            bitcnt_q <= bit_count;
            s_on_q   <= start_on;
            s_off_q  <= start_off;
            o_on_q   <= one_on;
            o_off_q  <= one_off;
            z_on_q   <= zero_on;
            z_off_q  <= zero_off;
            stop_q   <= stop_en;
            reps_q   <= frame_total;
            gap_q    <= frame_gap;
            in_start <= 1'b1;
            idx      <= '0;
            len_eff  <= {1'b0, bit_count};
            on_cnt   <= '0;
            off_cnt  <= '0;
            rep_done <= '0;
            gate     <= 1'b0;
            busy     <= 1'b1;
          end
        end
        ST_RUN: begin
          if (tick) begin
            if (on_cnt < sym_on) begin
              gate   <= 1'b1;
              on_cnt <= on_cnt + 1'b1;
            end else if (off_cnt < sym_off) begin
              gate    <= 1'b0;
              off_cnt <= off_cnt + 1'b1;
            end else begin
              gate    <= 1'b0;
              on_cnt  <= '0;
              off_cnt <= '0;
              if (frame_end) begin
                if (last_frame) begin
                  state    <= ST_IDLE;
                  busy     <= 1'b0;
                  rep_done <= '0;
                end else begin
                  state    <= ST_WAIT;
                  rep_done <= rep_done + 1'b1;
                end
              end else if (in_start) begin
                in_start <= 1'b0;
              end else begin
                idx <= idx + 1'b1;
              end
            end
          end
        end
        ST_WAIT: begin
          if (gap_expire) begin
            state <= ST_RUN;
            if (mode_q == MODE_TWIN) begin
              in_start <= 1'b0;
              idx      <= TWIN_IDX;
              len_eff  <= {bitcnt_q, 1'b1};
            end else begin
              in_start <= 1'b1;
              idx      <= '0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !gate); // R6

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> (busy && $stable(gate))); // R3

  AST_GATE_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
    gate |-> (state == ST_RUN)); // R3

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && req && (mode != 2'd3)) |=> busy); // R2

  AST_RSVD_REJECT: assert property (@(posedge clk) disable iff (rst)
    (!busy && req && (mode == 2'd3)) |=> (!busy && !gate)); // R9

endmodule

// File: tb/irtx_frame_seq_tb_top.sv
module irtx_frame_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [39:0] frame_buf = '0;
  logic [5:0]  bit_count = '0;
  logic [7:0]  start_on = '0, start_off = '0, one_on = '0, one_off = '0;
  logic [7:0]  zero_on = '0, zero_off = '0, frame_total = '0;
  logic        stop_en = 1'b0;
  logic [15:0] frame_gap = '0;
  logic        gate, busy;

  always #10 clk = ~clk;

  irtx_frame_seq dut_i (
    .clk(clk), .rst(rst), .tick(tick), .req(req), .mode(mode),
    .frame_buf(frame_buf), .bit_count(bit_count),
    .start_on(start_on), .start_off(start_off),
    .one_on(one_on), .one_off(one_off),
    .zero_on(zero_on), .zero_off(zero_off),
    .stop_en(stop_en), .frame_total(frame_total), .frame_gap(frame_gap),
    .gate(gate), .busy(busy)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string cur_req = "R1";
  bit    exp_q[$];
  bit    egate = 1'b0;
  int    tick_div = 1;
  int    tick_ph = 0;

  function automatic logic [39:0] pack5(input logic [7:0] b0, b1, b2, b3, b4);
    return {b4, b3, b2, b1, b0};
  endfunction

  task automatic push_sym(input int on, input int off);
    repeat (on) exp_q.push_back(1'b1);
    repeat (off) exp_q.push_back(1'b0);
    exp_q.push_back(1'b0);
  endtask

  // Behavioural expectation: one queue entry per tick of gate level.
  task automatic build();
    int frames;
    frames = (frame_total == 0) ? 1 : int'(frame_total);
    for (int f = 0; f < frames; f++) begin
      int  first;
      int  last;
      bit  lastf;
      lastf = (f == frames - 1);
      if (mode == 2'd2 && f > 0) begin
        first = 16;
        last  = 2 * int'(bit_count) + 1;
      end else begin
        push_sym(start_on, start_off);
        first = 0;
        last  = int'(bit_count);
      end
      for (int n = first; n < last; n++) begin
        if (mode == 2'd1 && n == 16) begin
          push_sym(zero_on, start_off);
        end else begin
          int bi;
          bit b;
          bi = (mode == 2'd1 && n > 16) ? n - 1 : n;
          b  = (bi < 40) ? frame_buf[8*(bi/8) + 7 - (bi%8)] : 1'b0;
          if (b) push_sym(one_on, one_off);
          else   push_sym(zero_on, zero_off);
        end
      end
      if (stop_en) push_sym(zero_on, lastf ? 255 : int'(zero_off));
      if (!lastf) repeat ((frame_gap < 1) ? 1 : int'(frame_gap)) exp_q.push_back(1'b0);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      exp_q.delete();
      egate = 1'b0;
    end else if (exp_q.size() == 0 && req && mode != 2'd3) begin
      build();
    end else if (exp_q.size() != 0 && tick) begin
      egate = exp_q.pop_front();
    end
  end

  always @(negedge clk) begin
    if (tick_ph + 1 >= tick_div) begin
      tick = 1'b1;
      tick_ph = 0;
    end else begin
      tick = 1'b0;
      tick_ph++;
    end
  end

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (gate !== egate || busy !== (exp_q.size() != 0)) begin
        n_bad++;
        $display("FAIL %s cycle %0d: gate=%0b busy=%0b expected gate=%0b busy=%0b",
                 cur_req, cyc, gate, busy, egate, exp_q.size() != 0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL R6 watchdog: cycles=%0d expected below 150000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic fire();
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0 || busy) @(negedge clk);
    repeat (3) @(negedge clk);
    n_chk++;
    if (busy !== 1'b0 || gate !== 1'b0) begin
      n_bad++;
      $display("FAIL R6 end of %s: busy=%0b gate=%0b expected busy=0 gate=0", cur_req, busy, gate);
    end
  endtask

  task automatic set_times(input int so, sf, oo, of, zo, zf);
    start_on = 8'(so); start_off = 8'(sf);
    one_on = 8'(oo); one_off = 8'(of);
    zero_on = 8'(zo); zero_off = 8'(zf);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    n_chk++;
    if (gate !== 1'b0 || busy !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: gate=%0b busy=%0b expected 0 0", gate, busy);
    end
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R4 and R5: plain frame, stop symbol, single frame (255-tick stop pause)
    cur_req = "R4/R5";
    mode = 2'd0; frame_buf = pack5(8'hA5, 8'h3C, 8'h00, 8'h00, 8'h00);
    bit_count = 6'd16; set_times(3, 2, 1, 3, 1, 1);
    stop_en = 1'b1; frame_total = 8'd1; frame_gap = 16'd4;
    fire(); wait_done();

    // R3 and R6: sparse tick, three frames with gap
    cur_req = "R3/R6";
    tick_div = 3;
    mode = 2'd0; frame_buf = pack5(8'h96, 8'h00, 8'h00, 8'h00, 8'h00);
    bit_count = 6'd8; set_times(2, 2, 2, 1, 1, 2);
    stop_en = 1'b1; frame_total = 8'd3; frame_gap = 16'd5;
    fire(); wait_done();
    tick_div = 1;

    // R6: no stop symbol, two frames
    cur_req = "R6";
    mode = 2'd0; frame_buf = pack5(8'h5B, 8'h00, 8'h00, 8'h00, 8'h00);
    bit_count = 6'd7; set_times(1, 1, 3, 1, 1, 2);
    stop_en = 1'b0; frame_total = 8'd2; frame_gap = 16'd3;
    fire(); wait_done();

    // R7: sync marker after sixteen data symbols
    cur_req = "R7";
    mode = 2'd1; frame_buf = pack5(8'h12, 8'h34, 8'hC5, 8'h00, 8'h00);
    bit_count = 6'd25; set_times(4, 3, 1, 2, 1, 1);
    stop_en = 1'b1; frame_total = 8'd1; frame_gap = 16'd1;
    fire(); wait_done();

    // R8: twin frames, second frame from position 16
    cur_req = "R8";
    mode = 2'd2; frame_buf = pack5(8'hE1, 8'h70, 8'h1E, 8'h8F, 8'h00);
    bit_count = 6'd12; set_times(0, 0, 1, 2, 1, 1);
    stop_en = 1'b1; frame_total = 8'd2; frame_gap = 16'd6;
    fire(); wait_done();

    // R9: reserved mode rejected
    cur_req = "R9";
    mode = 2'd3; frame_buf = pack5(8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00);
    fire();
    repeat (3) begin
      @(negedge clk);
      n_chk++;
      if (busy !== 1'b0 || gate !== 1'b0) begin
        n_bad++;
        $display("FAIL R9 reserved mode: busy=%0b gate=%0b expected 0 0", busy, gate);
      end
    end

    // R2: request while busy is ignored
    cur_req = "R2";
    mode = 2'd0; frame_buf = pack5(8'hC3, 8'h00, 8'h00, 8'h00, 8'h00);
    bit_count = 6'd8; set_times(2, 1, 1, 2, 1, 1);
    stop_en = 1'b1; frame_total = 8'd1; frame_gap = 16'd2;
    fire();
    repeat (10) @(negedge clk);
    mode = 2'd1; frame_buf = pack5(8'h0F, 8'hF0, 8'h00, 8'h00, 8'h00);
    bit_count = 6'd20; set_times(6, 6, 4, 4, 3, 3);
    fire(); wait_done();

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule